// File: doc/BRIEF.md
# History Buffer Undo Log

This block keeps a small register file current as soon as each instruction finishes, and it keeps enough history to take those writes back. Every decoded instruction claims a slot in a circular log, in program order, and gets a tag for it. When an instruction finishes out of order, it gives its tag, its destination register and its result. The block copies the register's current contents into the instruction's slot and then writes the new result. Operand reads go straight to the register file and never look at the log.

When the oldest instruction retires cleanly, its slot is freed and nothing else changes. When the oldest instruction has to take an exception, the block walks the log from the youngest live slot back to the oldest, one slot per clock. For every slot that holds a saved value, it writes that value back, so the register file returns to its state before the oldest live instruction. While the walk runs, `busy` is high and new work is refused. A one-cycle `done` pulse follows the last restore.

Top module: `hist_undo_log`

## Requirements
- R1: After reset, every register reads zero, the log is empty, `alloc_ready` is 1 and `busy` and `done` are 0.
- R2: Accepted allocations receive tags 0,1,2,... counting modulo 8 from reset, and `alloc_tag` shows the tag the next allocation will get. With 8 live entries `alloc_ready` is 0 and an allocation request is ignored.
- R3: An accepted completion writes `cmpl_data` into register `cmpl_dst` at the clock edge that samples it, so `rd_data` shows the new value right after that edge.
- R4: A completion whose tag is not live, or whose entry has already completed, changes no register.
- R5: Retirement frees the oldest entry only if that entry has completed. Otherwise the request is ignored. Retirement never changes a register.
- R6: An exception restores, from youngest to oldest, the value saved by every completed live entry. Entries that have not completed are skipped. Each register therefore ends up holding the value it had before the oldest live instruction wrote it.
- R7: After the exception is sampled, `busy` is high for exactly one cycle per live entry. While `busy` is high, `alloc_ready` is 0 and allocation, completion and retirement requests are ignored.
- R8: `done` is high for exactly one cycle, the cycle after the last restore. An exception taken on an empty log raises `done` in the next cycle and never raises `busy`.
- R9: An exception sampled in the same cycle as an allocation, completion or retirement request takes precedence, and those requests are ignored.
- R10: After a rollback the log is empty, and the next allocation receives the tag of the oldest entry that was live when the exception was taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alloc_valid | input | 1 | Decode requests a log entry |
| alloc_ready | output | 1 | A log entry can be claimed this cycle |
| alloc_tag | output | 3 | Tag the next accepted allocation receives |
| cmpl_valid | input | 1 | An instruction has finished |
| cmpl_tag | input | 3 | Tag of the finishing instruction |
| cmpl_dst | input | 4 | Destination register of the finishing instruction |
| cmpl_data | input | 32 | Result to write |
| retire_valid | input | 1 | The oldest instruction retires without exception |
| exc_valid | input | 1 | The oldest instruction takes an exception; start the rollback |
| rd_addr | input | 4 | Operand read address |
| rd_data | output | 32 | Operand read data (combinational) |
| busy | output | 1 | Rollback walk in progress |
| done | output | 1 | One-cycle pulse after the rollback ends |

## Verification
The bench sends two writes in program order to the same register and checks that the rollback leaves the value from before both of them. A walk that ran oldest to youngest, or that restored only the latest write, would leave the intermediate value behind. It mixes completed and uncompleted entries in a log that has just wrapped, and it pokes the inputs while the walk is running. A design that did not skip slots without a saved value would zero registers, and one that did not block requests during the walk would let a late completion or allocation take effect. It also checks an exception on an empty log, an exception arriving together with other requests, refused allocations and retirements when the log is full, and the number of `busy` cycles and the timing of `done`.

// File: rtl/hbl_pkg.sv
package hbl_pkg;

  typedef enum logic [1:0] {
    RB_IDLE = 2'd0,
    RB_WALK = 2'd1,
    RB_DONE = 2'd2
  } rb_state_t;

  // Distance of a slot from the ring head, counted in program order.
  function automatic int ring_age(int tag, int head, int depth);
    return (tag - head + depth) % depth;
  endfunction

  // Slot just before idx on the ring (the youngest live slot when idx is the tail).
  function automatic int ring_prev(int idx, int depth);
    return (idx + depth - 1) % depth;
  endfunction

endpackage

// File: rtl/hbl_regfile.sv
module hbl_regfile #(
  parameter int NREG = 16,
  parameter int XLEN = 32,
  localparam int RW = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we,
  input  logic [RW-1:0]   waddr,
  input  logic [XLEN-1:0] wdata,
  input  logic [RW-1:0]   raddr_op,
  output logic [XLEN-1:0] rdata_op,
  input  logic [RW-1:0]   raddr_old,
  output logic [XLEN-1:0] rdata_old
);

  logic [XLEN-1:0] regs [NREG];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else if (we) begin
      regs[waddr] <= wdata;
    end
  end

  assign rdata_op  = regs[raddr_op];
  assign rdata_old = regs[raddr_old];

endmodule

// File: rtl/hbl_log.sv
module hbl_log
  import hbl_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int NREG  = 16,
  parameter int XLEN  = 32,
  localparam int TW = $clog2(DEPTH),
  localparam int CW = TW + 1,
  localparam int RW = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            alloc_en,
  input  logic            cmpl_req,
  input  logic [TW-1:0]   cmpl_tag,
  input  logic [RW-1:0]   cmpl_dst,
  input  logic [XLEN-1:0] cmpl_old,
  input  logic            retire_req,
  input  logic            step_en,
  output logic [TW-1:0]   tail_o,
  output logic            full_o,
  output logic            empty_o,
  output logic            last_o,
  output logic            cmpl_ok,
  output logic            retire_ok,
  output logic            rb_has,
  output logic [RW-1:0]   rb_dst,
  output logic [XLEN-1:0] rb_old
);

  logic [TW-1:0]   head_q, tail_q, tail_m1;
  logic [CW-1:0]   count_q;
  logic [DEPTH-1:0] done_q;
  logic [RW-1:0]   dst_q [DEPTH];
  logic [XLEN-1:0] old_q [DEPTH];
  logic [DEPTH-1:0] alloc_hit, cmpl_hit;
  logic            tag_live;

  assign tail_m1 = TW'(ring_prev(int'(tail_q), DEPTH));
  assign tag_live = ring_age(int'(cmpl_tag), int'(head_q), DEPTH) < int'(count_q);

  assign full_o  = (count_q == CW'(DEPTH));
  assign empty_o = (count_q == '0);
  assign last_o  = (count_q == CW'(1));
  assign tail_o  = tail_q;

  assign cmpl_ok   = cmpl_req && tag_live && !done_q[cmpl_tag];
  assign retire_ok = retire_req && !empty_o && done_q[head_q];

  assign rb_has = done_q[tail_m1];
  assign rb_dst = dst_q[tail_m1];
  assign rb_old = old_q[tail_m1];

  // Per-slot decode of this cycle's writes.
  for (genvar i = 0; i < DEPTH; i++) begin : g_hit
    assign alloc_hit[i] = alloc_en && (tail_q == TW'(i));
    assign cmpl_hit[i]  = cmpl_ok && (cmpl_tag == TW'(i));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        dst_q[i] <= '0;
        old_q[i] <= '0;
      end
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (alloc_hit[i]) begin
          done_q[i] <= 1'b0;
        end else if (cmpl_hit[i]) begin
          done_q[i] <= 1'b1;
          dst_q[i]  <= cmpl_dst;
          old_q[i]  <= cmpl_old;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q  <= '0;
      tail_q  <= '0;
      count_q <= '0;
    end else begin
      if (alloc_en)     tail_q <= tail_q + 1'b1;
      else if (step_en) tail_q <= tail_m1;
      if (retire_ok)    head_q <= head_q + 1'b1;
      count_q <= count_q + CW'(alloc_en) - CW'(retire_ok) - CW'(step_en);
    end
  end

endmodule

// File: rtl/hbl_rollback_fsm.sv
module hbl_rollback_fsm
  import hbl_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic exc_req,
  input  logic log_empty,
  input  logic log_last,
  output logic exc_take,
  output logic walking,
  output logic done_pulse
);

  rb_state_t state_q, state_d;

  assign exc_take = exc_req && (state_q != RB_WALK);

  always_comb begin
    state_d = state_q;
    case (state_q)
      RB_IDLE, RB_DONE: begin
        if (exc_take)              state_d = log_empty ? RB_DONE : RB_WALK;
        else                       state_d = RB_IDLE;
      end
      RB_WALK: if (log_last)       state_d = RB_DONE;
      default:                     state_d = RB_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= RB_IDLE;
    else        state_q <= state_d;
  end

  assign walking    = (state_q == RB_WALK);
  assign done_pulse = (state_q == RB_DONE);

endmodule

// File: rtl/hist_undo_log.sv
module hist_undo_log #(
  parameter int DEPTH = 8,
  parameter int NREG  = 16,
  parameter int XLEN  = 32,
  localparam int TW = $clog2(DEPTH),
  localparam int RW = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            alloc_valid,
  output logic            alloc_ready,
  output logic [TW-1:0]   alloc_tag,
  input  logic            cmpl_valid,
  input  logic [TW-1:0]   cmpl_tag,
  input  logic [RW-1:0]   cmpl_dst,
  input  logic [XLEN-1:0] cmpl_data,
  input  logic            retire_valid,
  input  logic            exc_valid,
  input  logic [RW-1:0]   rd_addr,
  output logic [XLEN-1:0] rd_data,
  output logic            busy,
  output logic            done
);

  // Named internal events, used by the bound checker.
  logic            walking, exc_take, done_pulse;
  logic            log_full, log_empty, log_last;
  logic            ops_open, alloc_fire, cmpl_req, retire_req;
  logic            cmpl_ok, retire_ok;
  logic            rb_has, restore_we, rf_we;
  logic [RW-1:0]   rb_dst, rf_waddr;
  logic [XLEN-1:0] rb_old, rf_wdata, old_val;

  assign ops_open    = !walking && !exc_valid;
  assign alloc_ready = !log_full && !walking;
  assign alloc_fire  = alloc_valid && alloc_ready && !exc_valid;
  assign cmpl_req    = cmpl_valid && ops_open;
  assign retire_req  = retire_valid && ops_open;

  assign restore_we = walking && rb_has;
  assign rf_we      = restore_we || cmpl_ok;
  assign rf_waddr   = restore_we ? rb_dst : cmpl_dst;
  assign rf_wdata   = restore_we ? rb_old : cmpl_data;

  hbl_regfile #(.NREG(NREG), .XLEN(XLEN)) u_rf (
    .clk       (clk),
    .rst_n     (rst_n),
    .we        (rf_we),
    .waddr     (rf_waddr),
    .wdata     (rf_wdata),
    .raddr_op  (rd_addr),
    .rdata_op  (rd_data),
    .raddr_old (cmpl_dst),
    .rdata_old (old_val)
  );

  hbl_log #(.DEPTH(DEPTH), .NREG(NREG), .XLEN(XLEN)) u_log (
    .clk        (clk),
    .rst_n      (rst_n),
    .alloc_en   (alloc_fire),
    .cmpl_req   (cmpl_req),
    .cmpl_tag   (cmpl_tag),
    .cmpl_dst   (cmpl_dst),
    .cmpl_old   (old_val),
    .retire_req (retire_req),
    .step_en    (walking),
    .tail_o     (alloc_tag),
    .full_o     (log_full),
    .empty_o    (log_empty),
    .last_o     (log_last),
    .cmpl_ok    (cmpl_ok),
    .retire_ok  (retire_ok),
    .rb_has     (rb_has),
    .rb_dst     (rb_dst),
    .rb_old     (rb_old)
  );

  hbl_rollback_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .exc_req    (exc_valid),
    .log_empty  (log_empty),
    .log_last   (log_last),
    .exc_take   (exc_take),
    .walking    (walking),
    .done_pulse (done_pulse)
  );

  assign busy = walking;
  assign done = done_pulse;

endmodule

// File: rtl/hbl_checker.sv
module hbl_checker (
  input logic clk,
  input logic rst_n,
  input logic busy,
  input logic done,
  input logic alloc_ready,
  input logic alloc_fire,
  input logic cmpl_ok,
  input logic retire_ok,
  input logic log_full,
  input logic log_empty,
  input logic log_last,
  input logic exc_take
);

  // R2: a full log refuses allocations
  a_r2_full_refuses: assert property (@(posedge clk) disable iff (!rst_n)
    log_full |-> !alloc_ready);

  // R5: retirement only frees a live entry
  a_r5_retire_live: assert property (@(posedge clk) disable iff (!rst_n)
    retire_ok |-> !log_empty);

  // R7: nothing else moves during the walk
  a_r7_busy_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (!alloc_fire && !cmpl_ok && !retire_ok && !alloc_ready));

  // R8: done follows the last restore
  a_r8_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && log_last) |=> (done && !busy));

  // R8: done lasts a single cycle unless a new exception is taken on it
  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !exc_take) |=> !done);

  // R8: exception on an empty log goes straight to done
  a_r8_empty_exc: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_take && log_empty) |=> (done && !busy));

  // R9: an exception wins over same-cycle requests
  a_r9_exc_priority: assert property (@(posedge clk) disable iff (!rst_n)
    exc_take |-> (!alloc_fire && !cmpl_ok && !retire_ok));

endmodule

bind hist_undo_log hbl_checker u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .busy        (busy),
  .done        (done),
  .alloc_ready (alloc_ready),
  .alloc_fire  (alloc_fire),
  .cmpl_ok     (cmpl_ok),
  .retire_ok   (retire_ok),
  .log_full    (log_full),
  .log_empty   (log_empty),
  .log_last    (log_last),
  .exc_take    (exc_take)
);

// File: tb/test_hist_undo_log.sv
module test_hist_undo_log;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        alloc_valid = 1'b0;
  logic        alloc_ready;
  logic [2:0]  alloc_tag;
  logic        cmpl_valid = 1'b0;
  logic [2:0]  cmpl_tag = '0;
  logic [3:0]  cmpl_dst = '0;
  logic [31:0] cmpl_data = '0;
  logic        retire_valid = 1'b0;
  logic        exc_valid = 1'b0;
  logic [3:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        busy, done;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;
  int next_tag = 0;

  typedef struct {
    string       req;
    int          r;
    logic [31:0] v;
  } reg_exp_t;
  reg_exp_t sb_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  hist_undo_log i_hist_undo_log (
    .clk(clk), .rst_n(rst_n),
    .alloc_valid(alloc_valid), .alloc_ready(alloc_ready), .alloc_tag(alloc_tag),
    .cmpl_valid(cmpl_valid), .cmpl_tag(cmpl_tag), .cmpl_dst(cmpl_dst), .cmpl_data(cmpl_data),
    .retire_valid(retire_valid), .exc_valid(exc_valid),
    .rd_addr(rd_addr), .rd_data(rd_data), .busy(busy), .done(done)
  );

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  // Scoreboard driver side: queue an expected register value.
  task automatic expect_reg(string req, int r, logic [31:0] v);
    reg_exp_t e;
    e.req = req; e.r = r; e.v = v;
    sb_q.push_back(e);
  endtask

  // Scoreboard monitor side: read every queued register and compare.
  task automatic drain_regs();
    while (sb_q.size() > 0) begin
      reg_exp_t e = sb_q.pop_front();
      rd_addr = 4'(e.r);
      #1;
      check(e.req, $sformatf("r%0d", e.r), rd_data, e.v);
    end
  endtask

  task automatic do_alloc(string req);
    check(req, "alloc_ready", {31'b0, alloc_ready}, 32'd1);
    check(req, "alloc_tag", {29'b0, alloc_tag}, 32'(next_tag));
    alloc_valid = 1'b1;
    tick();
    alloc_valid = 1'b0;
    next_tag = (next_tag + 1) % 8;
  endtask

  task automatic do_cmpl(int tag, int dst, logic [31:0] data);
    cmpl_valid = 1'b1; cmpl_tag = 3'(tag); cmpl_dst = 4'(dst); cmpl_data = data;
    tick();
    cmpl_valid = 1'b0;
  endtask

  task automatic do_retire();
    retire_valid = 1'b1;
    tick();
    retire_valid = 1'b0;
  endtask

  // Raise an exception, count busy cycles, check the done pulse.
  // With poke set, requests are driven throughout the walk.
  task automatic rollback(string req, int exp_busy, bit poke);
    int n = 0;
    exc_valid = 1'b1;
    tick();
    exc_valid = 1'b0;
    while (busy === 1'b1 && n < 40) begin
      if (poke) begin
        check("R7", "alloc_ready during walk", {31'b0, alloc_ready}, 32'd0);
        alloc_valid = 1'b1; retire_valid = 1'b1;
        cmpl_valid = 1'b1; cmpl_tag = 3'd2; cmpl_dst = 4'd9; cmpl_data = 32'hDEAD;
      end
      n++;
      tick();
    end
    alloc_valid = 1'b0; retire_valid = 1'b0; cmpl_valid = 1'b0;
    check(req, "busy cycles", 32'(n), 32'(exp_busy));
    check("R8", "done after walk", {31'b0, done}, 32'd1);
    tick();
    check("R8", "done single cycle", {31'b0, done}, 32'd0);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    check("R1", "alloc_ready", {31'b0, alloc_ready}, 32'd1);
    check("R1", "busy", {31'b0, busy}, 32'd0);
    check("R1", "done", {31'b0, done}, 32'd0);
    for (int r = 0; r < 16; r += 5) expect_reg("R1", r, 32'h0);
    drain_regs();

    // R2: tags in order; R3: immediate writes
    do_alloc("R2");          // tag 0
    do_alloc("R2");          // tag 1
    do_alloc("R2");          // tag 2
    do_cmpl(0, 3, 32'h11);
    expect_reg("R3", 3, 32'h11);
    drain_regs();
    do_cmpl(1, 3, 32'h22);
    do_cmpl(2, 5, 32'h55);
    expect_reg("R3", 3, 32'h22);
    expect_reg("R3", 5, 32'h55);
    drain_regs();

    // R4: repeat completion and dead tag are ignored
    do_cmpl(1, 3, 32'h99);
    do_cmpl(5, 7, 32'h77);
    expect_reg("R4", 3, 32'h22);
    expect_reg("R4", 7, 32'h0);
    drain_regs();

    // R5: retire completed oldest (tag 0); registers unchanged
    do_retire();
    expect_reg("R5", 3, 32'h22);
    drain_regs();

    // R6: rollback of tags 2 then 1, youngest first
    rollback("R7", 2, 1'b0);
    expect_reg("R6", 3, 32'h11);
    expect_reg("R6", 5, 32'h0);
    drain_regs();
    next_tag = 1;            // R10: oldest live tag was 1

    // R2: fill the log, wrapping past tag 7
    for (int k = 0; k < 8; k++) do_alloc("R10");
    check("R2", "alloc_ready full", {31'b0, alloc_ready}, 32'd0);
    alloc_valid = 1'b1;
    tick();
    alloc_valid = 1'b0;
    // R5: uncompleted oldest cannot retire
    do_retire();
    check("R5", "retire ignored", {31'b0, alloc_ready}, 32'd0);
    do_cmpl(1, 1, 32'hA);
    do_retire();
    check("R5", "retire frees", {31'b0, alloc_ready}, 32'd1);
    check("R2", "tag after full", {29'b0, alloc_tag}, 32'd1);
    do_cmpl(3, 2, 32'hB);
    do_cmpl(4, 2, 32'hC);
    expect_reg("R3", 2, 32'hC);
    drain_regs();

    // R6/R7: 7 live entries, only two completed, pokes during walk
    rollback("R7", 7, 1'b1);
    expect_reg("R6", 2, 32'h0);
    expect_reg("R6", 1, 32'hA);
    expect_reg("R7", 9, 32'h0);
    drain_regs();
    next_tag = 2;
    check("R10", "tag after rollback", {29'b0, alloc_tag}, 32'(next_tag));

    // R8: exception on an empty log
    rollback("R8", 0, 1'b0);

    // R9: exception with same-cycle requests
    do_alloc("R10");         // tag 2
    do_cmpl(2, 4, 32'h44);
    expect_reg("R3", 4, 32'h44);
    drain_regs();
    alloc_valid = 1'b1; retire_valid = 1'b1;
    cmpl_valid = 1'b1; cmpl_tag = 3'd2; cmpl_dst = 4'd6; cmpl_data = 32'h66;
    rollback("R9", 1, 1'b0);
    expect_reg("R9", 4, 32'h0);
    expect_reg("R9", 6, 32'h0);
    drain_regs();
    check("R9", "alloc ignored", {29'b0, alloc_tag}, 32'd2);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule